// File: doc/BRIEF.md
# Buffered Four-Channel PWM Generator

This block produces four pulse-width-modulated outputs from one shared up-counting timer. Software writes a period value and one duty value per channel into buffer registers through a single-cycle write port. At each period boundary, the cycle in which the timer wraps from the active period value back to zero, all buffers are copied into the active registers together. The timer and the four comparators use only the active values.

A separate control register holds a hold bit. While that bit is set, no transfer takes place at a boundary. Software can therefore rewrite any mix of buffers over several cycles, or over several periods, and then clear the bit. The whole set of new values then starts together at the next boundary.

The current timer count is also an output, so that other logic can follow where the waveform is within the period.

Top module: `quad_pwm_core`

## Requirements
- R1: After reset the timer is 0, every output is low, every duty value (buffer and active) is 0, both period values equal the parameter RST_PERIOD (default 99), and the hold bit is clear.
- R2: Write address map: an address below N_CH (0..3) selects that channel's duty buffer. Address N_CH (4) selects the period buffer. Address N_CH+1 (5) selects the control register, whose bit 0 is the hold bit. Writes to any higher address (6, 7) change nothing.
- R3: A buffer write never changes the active values in the middle of a period. The outputs keep their waveform until a boundary.
- R4: The timer counts up by one per cycle from 0 to the active period value inclusive. In the cycle after it equals the active period, it reads 0.
- R5: Output i is high exactly when the timer count is less than channel i's active duty value. A duty of 0 keeps the output low, and a duty greater than the active period keeps it high.
- R6: At a boundary with the hold bit clear, the period buffer and all four duty buffers are copied into the active registers in that same cycle.
- R7: At a boundary with the hold bit set, every active value stays unchanged, so the old waveform continues.
- R8: If the hold bit is cleared partway through a period, the buffered values take effect at the next boundary, all channels on the same boundary.
- R9: A transfer uses the buffer contents and the hold bit as they stood before the boundary clock edge. A buffer write, or a hold-bit change, made in the boundary cycle itself applies only from the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one register per cycle |
| wr_addr | input | ADDR_W (3) | Register select, map given in R2 |
| wr_data | input | CNT_W (16) | Write data |
| pwm_out | output | N_CH (4) | PWM outputs, bit i for channel i |
| timer_count | output | CNT_W (16) | Current count of the shared timer |

## Verification
A register write and a period-boundary transfer can occur in the same cycle, and so can a change of the hold bit and a boundary. The bench provokes both cases by launching a duty write, and separately a hold-bit clear, in exactly the cycle in which the timer shows the active period value. It then judges the result through the outputs: the old duty must still be in force for the period that begins at that boundary, and the new duty must appear only one boundary later. A cycle-accurate scoreboard, built from the requirements, checks the timer and all four outputs on every cycle around these collisions.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DUTY,
        SEL_PERIOD,
        SEL_CTRL
    } sel_e;

    localparam int HOLD_BIT = 0;

    // Duty buffers occupy the low addresses, followed by period and control.
    function automatic sel_e decode_sel(input int unsigned addr, input int unsigned n_ch);
        if (addr < n_ch)          return SEL_DUTY;
        else if (addr == n_ch)    return SEL_PERIOD;
        else if (addr == n_ch + 1) return SEL_CTRL;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/pwm_buf_regs.sv
module pwm_buf_regs
    import pwm_bank_pkg::*;
#(
    parameter int          N_CH       = 4,
    parameter int          CNT_W      = 16,
    parameter int          ADDR_W     = 3,
    parameter int unsigned RST_PERIOD = 99
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [N_CH-1:0][CNT_W-1:0] duty_buf,
    output logic [CNT_W-1:0]           per_buf,
    output logic                       hold
);

    typedef struct packed {
        logic [N_CH-1:0][CNT_W-1:0] duty;
        logic [CNT_W-1:0]           per;
        logic                       hold;
    } buf_t;

    buf_t r_d, r_q;
    sel_e sel;

    always_comb begin
        r_d = r_q;
        sel = decode_sel(int'(wr_addr), N_CH);
        if (wr_en) begin
            unique case (sel)
                SEL_DUTY: begin
                    for (int i = 0; i < N_CH; i++) begin
                        if (wr_addr == ADDR_W'(i)) r_d.duty[i] = wr_data;
                    end
                end
                SEL_PERIOD: r_d.per  = wr_data;
                SEL_CTRL:   r_d.hold = wr_data[HOLD_BIT];
                default:    r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.duty <= '0;
            r_q.per  <= CNT_W'(RST_PERIOD);
            r_q.hold <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign duty_buf = r_q.duty;
    assign per_buf  = r_q.per;
    assign hold     = r_q.hold;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int          CNT_W      = 16,
    parameter int unsigned RST_PERIOD = 99
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] per_buf,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] per_act,
    output logic             xfer
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
    } tb_t;

    tb_t  s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == s_q.per);
        xfer = wrap && !hold;
        if (wrap) begin
            s_d.cnt = '0;
            if (!hold) s_d.per = per_buf;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.per <= CNT_W'(RST_PERIOD);
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.cnt;
    assign per_act = s_q.per;

endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xfer,
    input  logic [N_CH-1:0][CNT_W-1:0] duty_buf,
    input  logic [CNT_W-1:0]           count,
    output logic [N_CH-1:0][CNT_W-1:0] duty_act,
    output logic [N_CH-1:0]            pwm_out
);

    typedef struct packed {
        logic [N_CH-1:0][CNT_W-1:0] duty;
    } act_t;

    act_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (xfer) a_d.duty = duty_buf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign duty_act = a_q.duty;

    for (genvar g = 0; g < N_CH; g++) begin : g_cmp
        assign pwm_out[g] = (count < a_q.duty[g]);
    end

endmodule

// File: rtl/quad_pwm_core.sv
module quad_pwm_core #(
    parameter int          N_CH       = 4,
    parameter int          CNT_W      = 16,
    parameter int          ADDR_W     = $clog2(N_CH + 2),
    parameter int unsigned RST_PERIOD = 99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [N_CH-1:0]   pwm_out,
    output logic [CNT_W-1:0]  timer_count
);

    logic [N_CH-1:0][CNT_W-1:0] duty_buf;
    logic [N_CH-1:0][CNT_W-1:0] duty_act;
    logic [CNT_W-1:0]           per_buf;
    logic [CNT_W-1:0]           per_act;
    logic                       hold_q;
    logic                       xfer;

    pwm_buf_regs #(
        .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RST_PERIOD(RST_PERIOD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .duty_buf(duty_buf), .per_buf(per_buf), .hold(hold_q)
    );

    pwm_timebase #(
        .CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .hold(hold_q), .per_buf(per_buf),
        .count(timer_count), .per_act(per_act), .xfer(xfer)
    );

    pwm_duty_bank #(
        .N_CH(N_CH), .CNT_W(CNT_W)
    ) u_duty (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .duty_buf(duty_buf),
        .count(timer_count), .duty_act(duty_act), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/pwm_core_chk.sv
module pwm_core_chk #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [CNT_W-1:0]           timer,
    input logic [CNT_W-1:0]           per_act,
    input logic [CNT_W-1:0]           per_buf,
    input logic [N_CH-1:0][CNT_W-1:0] duty_act,
    input logic [N_CH-1:0][CNT_W-1:0] duty_buf,
    input logic                       hold,
    input logic [N_CH-1:0]            pwm
);

    // R4
    timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer == per_act) |=> (timer == '0));

    // R4
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer != per_act) |=> (timer == CNT_W'($past(timer) + 1'b1)));

    // R3
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer != per_act) |=> ($stable(duty_act) && $stable(per_act)));

    // R7
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((timer == per_act) && hold) |=> ($stable(duty_act) && $stable(per_act)));

    // R6
    boundary_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((timer == per_act) && !hold) |=>
            ((duty_act == $past(duty_buf)) && (per_act == $past(per_buf))));

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        // R5
        zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_act[g] == '0) |-> !pwm[g]);
        // R5
        over_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_act[g] > per_act) |-> pwm[g]);
    end

endmodule

bind quad_pwm_core pwm_core_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .timer(timer_count), .per_act(per_act),
    .per_buf(per_buf), .duty_act(duty_act), .duty_buf(duty_buf),
    .hold(hold_q), .pwm(pwm_out)
);

// File: tb/quad_pwm_core_bench.sv
`timescale 1ns/1ps
module quad_pwm_core_bench;

    localparam int N_CH    = 4;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int RST_PER = 99;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [N_CH-1:0]   pwm_out;
    logic [CNT_W-1:0]  timer_count;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    quad_pwm_core #(
        .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RST_PERIOD(RST_PER)
    ) u_quad_pwm_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .timer_count(timer_count)
    );

    typedef struct {
        int              timer;
        logic [N_CH-1:0] pwm;
    } item_t;

    item_t sb_q[$];

    // Reference state derived from the requirements
    int m_timer, m_per, m_pbuf;
    int m_dact[N_CH];
    int m_dbuf[N_CH];
    bit m_hold;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: advance the reference by one edge and
    // queue what the outputs must show afterwards.
    task automatic push_expect();
        item_t it;
        bit    wrap;
        bit    old_hold;
        wrap     = (m_timer == m_per);
        old_hold = m_hold;
        if (wrap) begin
            m_timer = 0;
            if (!old_hold) begin // R6 / R7 / R9: pre-edge buffers and hold bit
                m_per = m_pbuf;
                for (int i = 0; i < N_CH; i++) m_dact[i] = m_dbuf[i];
            end
        end else begin
            m_timer = m_timer + 1;
        end
        if (wr_en) begin // R2 map
            if (int'(wr_addr) < N_CH)       m_dbuf[int'(wr_addr)] = int'(wr_data);
            else if (int'(wr_addr) == N_CH) m_pbuf = int'(wr_data);
            else if (int'(wr_addr) == N_CH + 1) m_hold = wr_data[0];
        end
        it.timer = m_timer;
        for (int i = 0; i < N_CH; i++) it.pwm[i] = (m_timer < m_dact[i]);
        sb_q.push_back(it);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_timer = 0; m_per = RST_PER; m_pbuf = RST_PER; m_hold = 0;
            for (int i = 0; i < N_CH; i++) begin m_dact[i] = 0; m_dbuf[i] = 0; end
            sb_q.delete();
        end else begin
            push_expect();
        end
    end

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0 && !done) begin
            item_t it;
            it = sb_q.pop_front();
            check(int'(timer_count) == it.timer, "R4", "timer count",
                  int'(timer_count), it.timer);
            check(pwm_out == it.pwm, "R5", "pwm outputs", int'(pwm_out), int'(it.pwm));
        end
    end

    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic to_timer(input int v);
        while (int'(timer_count) != v) @(negedge clk);
    endtask

    task automatic expect_pwm(input logic [N_CH-1:0] exp, input string tag);
        check(pwm_out == exp, tag, "pwm pattern", int'(pwm_out), int'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(timer_count == '0, "R1", "timer in reset", int'(timer_count), 0);
        expect_pwm(4'b0000, "R1");
        rst_n = 1'b1;

        // New set: duties 3,5,0,12 and period 9, written mid-period
        wr(0, 3); wr(1, 5); wr(2, 0); wr(3, 12); wr(4, 9);
        expect_pwm(4'b0000, "R3");
        to_timer(RST_PER);
        @(negedge clk);
        check(timer_count == '0, "R1", "wrap at reset period", int'(timer_count), 0);
        expect_pwm(4'b1011, "R6");
        to_timer(4);
        expect_pwm(4'b1010, "R5");
        to_timer(9);
        @(negedge clk);
        check(timer_count == '0, "R6", "wrap at new period 9", int'(timer_count), 0);

        // Hold set, rewrite everything, carry the hold across a boundary
        wr(5, 1);
        wr(0, 8); wr(1, 1); wr(2, 9); wr(3, 2); wr(4, 5);
        to_timer(9);
        @(negedge clk);
        to_timer(7);
        check(timer_count == 16'd7, "R7", "old period still active", int'(timer_count), 7);
        expect_pwm(4'b1000, "R7");

        // Release mid-period: nothing changes until the boundary
        to_timer(3);
        wr(5, 0);
        expect_pwm(4'b1010, "R8");
        to_timer(9);
        @(negedge clk);
        expect_pwm(4'b1111, "R8");
        @(negedge clk);
        expect_pwm(4'b1101, "R8");
        to_timer(5);
        @(negedge clk);
        check(timer_count == '0, "R8", "wrap at released period 5", int'(timer_count), 0);

        // Duty write in the boundary cycle itself
        to_timer(5);
        wr(0, 0);
        check(pwm_out[0] == 1'b1, "R9", "ch0 keeps old duty", int'(pwm_out[0]), 1);
        to_timer(5);
        @(negedge clk);
        expect_pwm(4'b1110, "R9");

        // Hold cleared in the boundary cycle itself
        wr(5, 1);
        wr(1, 4);
        to_timer(5);
        wr(5, 0);
        to_timer(2);
        check(pwm_out[1] == 1'b0, "R9", "ch1 old duty after late release",
              int'(pwm_out[1]), 0);
        to_timer(5);
        @(negedge clk);
        to_timer(2);
        check(pwm_out[1] == 1'b1, "R9", "ch1 new duty one boundary later",
              int'(pwm_out[1]), 1);

        // Unmapped addresses change nothing
        wr(6, 0); wr(7, 0);
        to_timer(5);
        @(negedge clk);
        to_timer(2);
        expect_pwm(4'b0110, "R2");
        to_timer(5);
        @(negedge clk);
        check(timer_count == '0, "R2", "period untouched", int'(timer_count), 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule